// File: doc/BRIEF.md
# Logic and Compare ALU Slice with Flags

This block is the purely combinational slice of an accumulator CPU's ALU that handles the three bitwise logic operations and the compare operation. The accumulator value and a second operand arrive on separate inputs. The operand source (register, immediate byte or memory byte) is selected outside the block. A 2-bit operation code picks what the slice computes.

The slice returns the value to be written back to the accumulator, together with a write-enable that tells the register file whether to commit it. It also returns the zero, subtract, half-carry and carry flags, both as four separate bits and packed into an 8-bit flag byte. The flag byte is ready to be stored in the flag register or pushed to the stack.

Compare works like a subtraction whose result is thrown away. It changes only the flags. The accumulator output then carries the input accumulator unchanged, and the write-enable is low.

Top module: `lcalu_top`

## Requirements
- R1: With op code 0 (AND), the result is acc AND operand, the write-enable is 1, zero is set exactly when the result is 0, subtract is 0, carry is 0 and half-carry is 1.
- R2: With op code 1 (XOR), the result is acc XOR operand, the write-enable is 1, zero is set exactly when the result is 0, and subtract, half-carry and carry are all 0.
- R3: With op code 2 (OR), the result is acc OR operand, the write-enable is 1, zero is set exactly when the result is 0, and subtract, half-carry and carry are all 0.
- R4: With op code 3 (compare), subtract is 1, zero is set exactly when acc equals the operand, and carry is set exactly when the operand, taken as unsigned, exceeds acc.
- R5: With op code 3, half-carry is set exactly when the low 4 bits of acc, taken as unsigned, are less than the low 4 bits of the operand.
- R6: With op code 3, the write-enable is 0 and the accumulator output equals the accumulator input.
- R7: The flag byte carries zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3 to 0 are always 0. All four fields match the separate flag outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| op_i | input | 2 | Operation: 0 AND, 1 XOR, 2 OR, 3 compare |
| acc_o | output | 8 | Value for the accumulator |
| acc_we_o | output | 1 | Accumulator write-enable |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Subtract flag |
| h_o | output | 1 | Half-carry flag |
| c_o | output | 1 | Carry flag |
| flags_o | output | 8 | Packed flag byte |

## Verification
The slice has no state, so any fault shows at the ports in the same evaluation in which the inputs settle. Each checked vector is therefore self-contained.

A wrong internal borrow or nibble-borrow signal shows as a wrong carry or half-carry bit only under compare. For that reason the bench pairs operands on both sides of equality, in the full byte and in the low nibble.

A broken operation decode shows as a wrong write-enable, a changed accumulator under compare, or a half-carry bit that does not match the operation. A packing fault shows only on the flag byte, while the separate flag bits stay correct.

// File: rtl/lcalu_pkg.sv
package lcalu_pkg;
  localparam int FLAG_BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_XOR = 2'd1,
    OP_OR  = 2'd2,
    OP_CMP = 2'd3
  } lc_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } lc_flags_t;

  function automatic logic [FLAG_BYTE_W-1:0] pack_flags(input lc_flags_t f);
    return {f.z, f.n, f.h, f.c, 4'b0000};
  endfunction
endpackage

// File: rtl/lcalu_logic.sv
module lcalu_logic #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  lcalu_pkg::lc_op_e op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o
);
  import lcalu_pkg::*;

  function automatic logic [DATA_W-1:0] bitwise(input lc_op_e op,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    case (op)
      OP_AND:  return a & b;
      OP_XOR:  return a ^ b;
      OP_OR:   return a | b;
      default: return a;
    endcase
  endfunction

  assign res_o  = bitwise(op_i, a_i, b_i);
  assign zero_o = (res_o == '0);
endmodule

// File: rtl/lcalu_cmp.sv
module lcalu_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              equal_o,
  output logic              borrow_o,
  output logic              half_borrow_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W:0] sub_ext(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [HALF_W:0] sub_low(input logic [HALF_W-1:0] a,
                                              input logic [HALF_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  logic [DATA_W:0] diff;
  logic [HALF_W:0] diff_low;

  assign diff          = sub_ext(a_i, b_i);
  assign diff_low      = sub_low(a_i[HALF_W-1:0], b_i[HALF_W-1:0]);
  assign equal_o       = (diff[DATA_W-1:0] == '0);
  assign borrow_o      = diff[DATA_W];
  assign half_borrow_o = diff_low[HALF_W];
endmodule

// File: rtl/lcalu_flag_pack.sv
module lcalu_flag_pack (
  input  lcalu_pkg::lc_flags_t                        flags_i,
  output logic [lcalu_pkg::FLAG_BYTE_W-1:0]           byte_o
);
  assign byte_o = lcalu_pkg::pack_flags(flags_i);
endmodule

// File: rtl/lcalu_top.sv
module lcalu_top #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        op_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              acc_we_o,
  output logic              z_o,
  output logic              n_o,
  output logic              h_o,
  output logic              c_o,
  output logic [7:0]        flags_o
);
  import lcalu_pkg::*;

  lc_op_e      op;
  logic [DATA_W-1:0] logic_res;
  logic        logic_zero;
  logic        cmp_equal;
  logic        cmp_borrow;
  logic        cmp_half_borrow;
  lc_flags_t   flags;

  assign op = lc_op_e'(op_i);

  lcalu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i    (acc_i),
    .b_i    (opnd_i),
    .op_i   (op),
    .res_o  (logic_res),
    .zero_o (logic_zero)
  );

  lcalu_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a_i           (acc_i),
    .b_i           (opnd_i),
    .equal_o       (cmp_equal),
    .borrow_o      (cmp_borrow),
    .half_borrow_o (cmp_half_borrow)
  );

  always_comb begin
    acc_o    = logic_res;
    acc_we_o = 1'b1;
    flags    = '{z: logic_zero, n: 1'b0, h: 1'b0, c: 1'b0};
    case (op)
      OP_AND: flags.h = 1'b1;
      OP_CMP: begin
        acc_o    = acc_i;
        acc_we_o = 1'b0;
        flags    = '{z: cmp_equal, n: 1'b1, h: cmp_half_borrow, c: cmp_borrow};
      end
      default: ;
    endcase
  end

  assign z_o = flags.z;
  assign n_o = flags.n;
  assign h_o = flags.h;
  assign c_o = flags.c;

  lcalu_flag_pack u_pack (
    .flags_i (flags),
    .byte_o  (flags_o)
  );
endmodule

// File: rtl/lcalu_top_chk.sv
module lcalu_top_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] acc_o,
  input logic              acc_we_o,
  input logic              z_o,
  input logic              n_o,
  input logic              h_o,
  input logic              c_o,
  input logic [7:0]        flags_o,
  input logic              cmp_borrow,
  input logic              cmp_half_borrow
);
  always_comb begin
    if (op_i == 2'd0) begin
      a_r1_and_flags: assert (h_o && !n_o && !c_o && acc_we_o && (z_o == (acc_o == '0)));
    end
    if (op_i == 2'd1 || op_i == 2'd2) begin
      a_r2_r3_clear_flags: assert (!n_o && !h_o && !c_o && acc_we_o && (z_o == (acc_o == '0)));
    end
    if (op_i == 2'd3) begin
      a_r4_cmp_flags: assert (n_o && (z_o == (acc_i == opnd_i)) && (c_o == cmp_borrow));
      a_r5_cmp_half: assert (h_o == cmp_half_borrow);
      a_r6_cmp_no_write: assert (!acc_we_o && (acc_o == acc_i));
    end
    a_r7_flag_byte: assert (flags_o == {z_o, n_o, h_o, c_o, 4'b0000});
  end
endmodule

bind lcalu_top lcalu_top_chk #(.DATA_W(DATA_W)) u_chk (
  .acc_i           (acc_i),
  .opnd_i          (opnd_i),
  .op_i            (op_i),
  .acc_o           (acc_o),
  .acc_we_o        (acc_we_o),
  .z_o             (z_o),
  .n_o             (n_o),
  .h_o             (h_o),
  .c_o             (c_o),
  .flags_o         (flags_o),
  .cmp_borrow      (cmp_borrow),
  .cmp_half_borrow (cmp_half_borrow)
);

// File: tb/lcalu_top_tb_top.sv
module lcalu_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] acc, opnd, acc_o, flags_o;
  logic [1:0] op;
  logic       we, z, n, h, c;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  lcalu_top dut_i (
    .acc_i (acc), .opnd_i (opnd), .op_i (op),
    .acc_o (acc_o), .acc_we_o (we),
    .z_o (z), .n_o (n), .h_o (h), .c_o (c),
    .flags_o (flags_o)
  );

  localparam int NVEC = 12;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hF0, 8'h0F}, {2'd0, 8'hFF, 8'h3C}, {2'd1, 8'hAA, 8'hAA},
    {2'd1, 8'h5A, 8'h0F}, {2'd2, 8'h00, 8'h00}, {2'd2, 8'h81, 8'h18},
    {2'd3, 8'h42, 8'h42}, {2'd3, 8'h10, 8'h20}, {2'd3, 8'h20, 8'h0F},
    {2'd3, 8'h3F, 8'h31}, {2'd3, 8'h00, 8'hFF}, {2'd3, 8'hFF, 8'h00}
  };

  task automatic expect_eq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d acc=%0h opnd=%0h)",
               req, act, exp, op, acc, opnd);
    end
  endtask

  task automatic apply_and_check(logic [1:0] o, logic [7:0] a, logic [7:0] b);
    int r, ez, en, eh, ec, ewe, diff, dlo;
    op = o; acc = a; opnd = b;
    #1;
    diff = int'(a) - int'(b);
    dlo  = int'(a % 16) - int'(b % 16);
    case (o)
      2'd0: begin r = a & b; ez = (r == 0); en = 0; eh = 1; ec = 0; ewe = 1; end
      2'd1: begin r = a ^ b; ez = (r == 0); en = 0; eh = 0; ec = 0; ewe = 1; end
      2'd2: begin r = a | b; ez = (r == 0); en = 0; eh = 0; ec = 0; ewe = 1; end
      default: begin r = a; ez = (diff == 0); en = 1; eh = (dlo < 0); ec = (diff < 0); ewe = 0; end
    endcase
    if (o == 2'd0) expect_eq("R1 and", {acc_o, we, z, n, h, c}, {r[7:0], ewe[0], ez[0], en[0], eh[0], ec[0]});
    if (o == 2'd1) expect_eq("R2 xor", {acc_o, we, z, n, h, c}, {r[7:0], ewe[0], ez[0], en[0], eh[0], ec[0]});
    if (o == 2'd2) expect_eq("R3 or",  {acc_o, we, z, n, h, c}, {r[7:0], ewe[0], ez[0], en[0], eh[0], ec[0]});
    if (o == 2'd3) begin
      expect_eq("R4 cmp z/n/c", {z, n, c}, {ez[0], en[0], ec[0]});
      expect_eq("R5 cmp half",  {31'd0, h}, eh);
      expect_eq("R6 cmp acc/we", {acc_o, we}, {r[7:0], 1'b0});
    end
    expect_eq("R7 flag byte", flags_o, {ez[0], en[0], eh[0], ec[0], 4'h0});
  endtask

  initial begin
    op = 2'd0; acc = 8'h00; opnd = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle inputs: AND of zeros gives zero with half-carry, flag byte A0
    expect_eq("R7 idle flag byte", flags_o, 8'hA0);
    expect_eq("R1 idle result", {acc_o, we}, {8'h00, 1'b1});
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply_and_check(VEC[i][17:16], VEC[i][15:8], VEC[i][7:0]);
    end

    // R5 corner: high byte larger but low nibble borrows
    @(negedge clk);
    apply_and_check(2'd3, 8'h50, 8'h0F);
    expect_eq("R5 nibble borrow without carry", {h, c}, 2'b10);
    // R4 corner: full borrow but no nibble borrow
    apply_and_check(2'd3, 8'h0F, 8'hF0);
    expect_eq("R4 carry without nibble borrow", {h, c}, 2'b01);
    // R6 corner: compare with equal values holds accumulator
    apply_and_check(2'd3, 8'hC3, 8'hC3);
    expect_eq("R6 compare holds acc", acc_o, 8'hC3);

    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 3)
        for (int o = 0; o < 4; o++)
          apply_and_check(o[1:0], a[7:0], b[7:0]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule